// File: doc/BRIEF.md
# Multi-Mode Video Pixel Output Formatter

This block places internal video samples onto a 24-bit pixel bus. Each cycle it accepts a luma (or green) component, two chroma (or blue and red) components of 12 bits, horizontal and vertical sync and a data-enable flag. An 8-bit format code selects one of eight lane layouts: four single-data-rate layouts (8, 12, 16 and 24 bit), one single-data-rate 4:4:4 RGB layout and three double-data-rate layouts. Every bus bit has its own output enable, and bits that a layout does not use are disabled.

In double-data-rate layouts the block keeps two registered half-words, one for the rising phase and one for the falling phase of the output clock. The `ddrPhase` input picks which one drives the bus, with 1 selecting the rising-phase word. In single-data-rate layouts both half-words are equal. All data, enable and sync outputs are registered once, so an input sampled at one clock edge appears on the outputs after that edge. The word index used for chroma alternation and pixel pairing restarts at 0 on the first active cycle after data-enable rises.

Top module: `pix_out_formatter`

## Requirements
- R1: Code 0x00 (8-bit 4:2:2 interleaved): from data-enable rise, word index 0,1,2,3 repeating places Cb, Y, Cr, Y bits [11:4] on bus [15:8]; enable mask is 0x00FF00.
- R2: Code 0x0A (12-bit 4:2:2 interleaved): same word order as R1, bits [11:4] on bus [15:8] and bits [3:0] on bus [23:20]; enable mask is 0xF0FF00.
- R3: Code 0x80 (16-bit 4:2:2): Y[11:4] on bus [15:8], chroma [11:4] on bus [7:0], chroma Cb at even pixel index from data-enable rise and Cr at odd; enable mask is 0x00FFFF.
- R4: Code 0x8A (24-bit 4:2:2): Y[11:4] on [15:8], Y[3:0] on [23:20], chroma [11:4] on [7:0], chroma [3:0] on [19:16], chroma alternating as in R3; all 24 bits enabled.
- R5: Code 0x40 (4:4:4 RGB): red [11:4] on [23:16], green [11:4] on [15:8], blue [11:4] on [7:0]; all bits enabled.
- R6: Code 0x20 (8-bit DDR 4:2:2): rising-phase word carries chroma [11:4] on [15:8] (Cb even pixel, Cr odd), falling-phase word carries Y[11:4] on [15:8]; enable mask 0x00FF00.
- R7: Code 0x2A (12-bit DDR 4:2:2): as R6 with component bits [3:0] additionally on [23:20] of each phase word; enable mask 0xF0FF00.
- R8: Code 0x60 (24-bit DDR RGB): an even-index pixel is stored; the following odd-index pixel updates both phase words, rising = stored even pixel, falling = odd pixel, in the R5 lane layout; during an even active pixel the phase words hold; all bits enabled.
- R9: Any other code drives all enables to 0, the bus to 0 and the sync and data-enable outputs to 0.
- R10: Disabled bus bits read 0; a cycle with data-enable low yields an all-zero bus after the edge; in a recognised mode sync and data-enable outputs equal their inputs one cycle earlier.
- R11: While reset is asserted all outputs are 0.
- R12: In single-data-rate codes (0x00, 0x0A, 0x80, 0x8A, 0x40) the bus value does not depend on `ddrPhase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fmtCode | input | 8 | Output format code |
| inDe | input | 1 | Input data-enable |
| inHs | input | 1 | Input horizontal sync |
| inVs | input | 1 | Input vertical sync |
| lumaG | input | 12 | Luma or green component |
| cbB | input | 12 | Cb or blue component |
| crR | input | 12 | Cr or red component |
| ddrPhase | input | 1 | Output clock phase: 1 rising word, 0 falling word |
| pixOut | output | 24 | Pixel bus data |
| pixOe | output | 24 | Per-bit output enable |
| hsOut | output | 1 | Registered horizontal sync |
| vsOut | output | 1 | Registered vertical sync |
| deOut | output | 1 | Registered data-enable |

## Verification
The assertions check on every cycle that the enable mask matches the previous cycle's format code, that unrecognised codes silence the bus and sync outputs, that disabled bits read zero, that blanking yields a zero bus and that data-enable trails its input by one cycle. The word order Cb, Y, Cr, Y, the restart of chroma alternation at data-enable rise, the pairing and holding of DDR RGB pixels, and the lane placement of split low bits depend on history and data values, so only the bench's model comparison over directed and random scenarios shows them, including independence from `ddrPhase` in single-data-rate codes.

// File: rtl/pix_fmt_pkg.sv
package pix_fmt_pkg;
  localparam int COMP_W = 12;
  localparam int BUS_W  = 24;
  localparam int CODE_W = 8;
  localparam int HI_W   = 8;
  localparam int LO_W   = COMP_W - HI_W;
  localparam int IDX_W  = 2;

  typedef enum logic [3:0] {
    MD_OFF, MD_N8, MD_N12, MD_W16, MD_W24, MD_RGB, MD_D8, MD_D12, MD_DRGB
  } fmtMode_e;

  typedef struct packed {
    logic active;     // data-enable high in a recognised mode
    logic pickLuma;   // narrow modes: this word carries luma
    logic pickCr;     // chroma word is Cr rather than Cb
    logic pairStore;  // DDR RGB: even pixel, keep it
    logic pairLoad;   // DDR RGB: odd pixel, update both phase words
    logic modeKnown;  // format code recognised
  } fmtStrobe_t;

  typedef logic [BUS_W-1:0] busWord_t;

  function automatic fmtMode_e decodeCode(input logic [CODE_W-1:0] code);
    case (code)
      8'h00:   return MD_N8;
      8'h0A:   return MD_N12;
      8'h80:   return MD_W16;
      8'h8A:   return MD_W24;
      8'h40:   return MD_RGB;
      8'h20:   return MD_D8;
      8'h2A:   return MD_D12;
      8'h60:   return MD_DRGB;
      default: return MD_OFF;
    endcase
  endfunction

  function automatic busWord_t enableMask(input fmtMode_e mode);
    case (mode)
      MD_N8, MD_D8:                  return 24'h00FF00;
      MD_N12, MD_D12:                return 24'hF0FF00;
      MD_W16:                        return 24'h00FFFF;
      MD_W24, MD_RGB, MD_DRGB:       return 24'hFFFFFF;
      default:                       return '0;
    endcase
  endfunction
endpackage

// File: rtl/pix_fmt_ctrl.sv
module pix_fmt_ctrl
  import pix_fmt_pkg::*;
#(
  parameter int IDX_BITS = IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] fmtCode,
  input  logic              inDe,
  output fmtMode_e          mode,
  output fmtStrobe_t        strobe
);
  logic                prevDe;
  logic [IDX_BITS-1:0] idxQ;
  logic [IDX_BITS-1:0] idxCur;
  logic                narrow;
  logic                ddrRgb;

  always_comb begin
    mode   = decodeCode(fmtCode);
    idxCur = prevDe ? idxQ : '0;
    narrow = (mode == MD_N8) || (mode == MD_N12);
    ddrRgb = (mode == MD_DRGB);

    strobe.modeKnown = (mode != MD_OFF);
    strobe.active    = inDe && (mode != MD_OFF);
    strobe.pickLuma  = narrow && idxCur[0];
    strobe.pickCr    = narrow ? idxCur[1] : idxCur[0];
    strobe.pairStore = inDe && ddrRgb && !idxCur[0];
    strobe.pairLoad  = inDe && ddrRgb && idxCur[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevDe <= 1'b0;
      idxQ   <= '0;
    end else begin
      prevDe <= inDe;
      if (inDe) idxQ <= idxCur + 1'b1;
    end
  end
endmodule

// File: rtl/pix_fmt_datapath.sv
module pix_fmt_datapath
  import pix_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fmtMode_e          mode,
  input  fmtStrobe_t        strobe,
  input  logic              inHs,
  input  logic              inVs,
  input  logic              inDe,
  input  logic [COMP_W-1:0] lumaG,
  input  logic [COMP_W-1:0] cbB,
  input  logic [COMP_W-1:0] crR,
  input  logic              ddrPhase,
  output logic [BUS_W-1:0]  pixOut,
  output logic [BUS_W-1:0]  pixOe,
  output logic              hsOut,
  output logic              vsOut,
  output logic              deOut
);
  busWord_t riseQ, fallQ, holdQ, oeQ;
  busWord_t riseN, fallN;
  busWord_t rgbWord;
  logic [COMP_W-1:0] chroma, narrowWord;
  logic [2:0] syncQ;

  // upper component bits on the middle lane, low bits optionally on top nibble
  function automatic busWord_t packNarrow(input logic [COMP_W-1:0] w, input logic withLow);
    busWord_t r;
    r = '0;
    r[15:8] = w[COMP_W-1:LO_W];
    if (withLow) r[23:20] = w[LO_W-1:0];
    return r;
  endfunction

  function automatic busWord_t packWide(input logic [COMP_W-1:0] y,
                                        input logic [COMP_W-1:0] c,
                                        input logic withLow);
    busWord_t r;
    r = '0;
    r[15:8] = y[COMP_W-1:LO_W];
    r[7:0]  = c[COMP_W-1:LO_W];
    if (withLow) begin
      r[23:20] = y[LO_W-1:0];
      r[19:16] = c[LO_W-1:0];
    end
    return r;
  endfunction

  function automatic busWord_t packRgb(input logic [COMP_W-1:0] g,
                                       input logic [COMP_W-1:0] b,
                                       input logic [COMP_W-1:0] r);
    return {r[COMP_W-1:LO_W], g[COMP_W-1:LO_W], b[COMP_W-1:LO_W]};
  endfunction

  always_comb begin
    chroma     = strobe.pickCr ? crR : cbB;
    narrowWord = strobe.pickLuma ? lumaG : chroma;
    rgbWord    = packRgb(lumaG, cbB, crR);
    riseN      = riseQ;
    fallN      = fallQ;
    if (!strobe.active) begin
      riseN = '0;
      fallN = '0;
    end else begin
      case (mode)
        MD_N8: begin
          riseN = packNarrow(narrowWord, 1'b0);
          fallN = riseN;
        end
        MD_N12: begin
          riseN = packNarrow(narrowWord, 1'b1);
          fallN = riseN;
        end
        MD_W16: begin
          riseN = packWide(lumaG, chroma, 1'b0);
          fallN = riseN;
        end
        MD_W24: begin
          riseN = packWide(lumaG, chroma, 1'b1);
          fallN = riseN;
        end
        MD_RGB: begin
          riseN = rgbWord;
          fallN = rgbWord;
        end
        MD_D8: begin
          riseN = packNarrow(chroma, 1'b0);
          fallN = packNarrow(lumaG, 1'b0);
        end
        MD_D12: begin
          riseN = packNarrow(chroma, 1'b1);
          fallN = packNarrow(lumaG, 1'b1);
        end
        MD_DRGB: begin
          if (strobe.pairLoad) begin
            riseN = holdQ;
            fallN = rgbWord;
          end
        end
        default: begin
          riseN = '0;
          fallN = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseQ <= '0;
      fallQ <= '0;
      holdQ <= '0;
      oeQ   <= '0;
      syncQ <= '0;
    end else begin
      riseQ <= riseN;
      fallQ <= fallN;
      if (strobe.pairStore) holdQ <= rgbWord;
      oeQ   <= enableMask(mode);
      syncQ <= strobe.modeKnown ? {inHs, inVs, inDe} : 3'b000;
    end
  end

  // per-pin phase multiplexer
  for (genvar b = 0; b < BUS_W; b++) begin : g_phaseMux
    assign pixOut[b] = ddrPhase ? riseQ[b] : fallQ[b];
  end

  assign pixOe = oeQ;
  assign hsOut = syncQ[2];
  assign vsOut = syncQ[1];
  assign deOut = syncQ[0];
endmodule

// File: rtl/pix_out_formatter.sv
module pix_out_formatter (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  fmtCode,
  input  logic        inDe,
  input  logic        inHs,
  input  logic        inVs,
  input  logic [11:0] lumaG,
  input  logic [11:0] cbB,
  input  logic [11:0] crR,
  input  logic        ddrPhase,
  output logic [23:0] pixOut,
  output logic [23:0] pixOe,
  output logic        hsOut,
  output logic        vsOut,
  output logic        deOut
);
  import pix_fmt_pkg::*;

  fmtMode_e   mode;
  fmtStrobe_t strobe;

  pix_fmt_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .fmtCode (fmtCode),
    .inDe    (inDe),
    .mode    (mode),
    .strobe  (strobe)
  );

  pix_fmt_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .mode     (mode),
    .strobe   (strobe),
    .inHs     (inHs),
    .inVs     (inVs),
    .inDe     (inDe),
    .lumaG    (lumaG),
    .cbB      (cbB),
    .crR      (crR),
    .ddrPhase (ddrPhase),
    .pixOut   (pixOut),
    .pixOe    (pixOe),
    .hsOut    (hsOut),
    .vsOut    (vsOut),
    .deOut    (deOut)
  );
endmodule

// File: rtl/pix_out_formatter_chk.sv
module pix_out_formatter_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  fmtCode,
  input logic        inDe,
  input logic [23:0] pixOut,
  input logic [23:0] pixOe,
  input logic        hsOut,
  input logic        vsOut,
  input logic        deOut
);
  logic seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  function automatic logic listed(input logic [7:0] c);
    return (c == 8'h00) || (c == 8'h0A) || (c == 8'h80) || (c == 8'h8A) ||
           (c == 8'h40) || (c == 8'h20) || (c == 8'h2A) || (c == 8'h60);
  endfunction

  AST_OE_NARROW8: assert property (@(posedge clk) disable iff (!rstN)
    seen && ($past(fmtCode) == 8'h00 || $past(fmtCode) == 8'h20) |-> pixOe == 24'h00FF00); // R1
  AST_OE_NIBBLE: assert property (@(posedge clk) disable iff (!rstN)
    seen && ($past(fmtCode) == 8'h0A || $past(fmtCode) == 8'h2A) |-> pixOe == 24'hF0FF00); // R2
  AST_OE_WIDE16: assert property (@(posedge clk) disable iff (!rstN)
    seen && $past(fmtCode) == 8'h80 |-> pixOe == 24'h00FFFF); // R3
  AST_OE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    seen && ($past(fmtCode) == 8'h8A || $past(fmtCode) == 8'h40 || $past(fmtCode) == 8'h60)
    |-> pixOe == 24'hFFFFFF); // R4
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    seen && !listed($past(fmtCode)) |-> (pixOe == 24'h0) && (pixOut == 24'h0) && !hsOut && !vsOut && !deOut); // R9
  AST_DATA_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (pixOut & ~pixOe) == 24'h0); // R10
  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    seen && !$past(inDe) |-> pixOut == 24'h0); // R10
  AST_DE_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    seen && listed($past(fmtCode)) |-> deOut == $past(inDe)); // R10
endmodule

bind pix_out_formatter pix_out_formatter_chk u_chk (.*);

// File: tb/pix_out_formatter_bench.sv
module pix_out_formatter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  fmtCode = 8'h00;
  logic        inDe = 1'b0, inHs = 1'b0, inVs = 1'b0;
  logic [11:0] lumaG = '0, cbB = '0, crR = '0;
  logic        ddrPhase = 1'b0;
  logic [23:0] pixOut, pixOe;
  logic        hsOut, vsOut, deOut;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  // bench model state
  logic [1:0]  mIdx = '0;
  logic        mPrevDe = 1'b0;
  logic [23:0] mHold = '0, mRise = '0, mFall = '0;
  logic [23:0] expOe = '0;
  logic [2:0]  expSync = '0;
  logic [7:0]  expCode = '0;
  logic        expBlank = 1'b0;
  bit          expValid = 0;

  always #5 clk = ~clk;

  pix_out_formatter u_pix_out_formatter (
    .clk(clk), .rstN(rstN), .fmtCode(fmtCode), .inDe(inDe), .inHs(inHs), .inVs(inVs),
    .lumaG(lumaG), .cbB(cbB), .crR(crR), .ddrPhase(ddrPhase),
    .pixOut(pixOut), .pixOe(pixOe), .hsOut(hsOut), .vsOut(vsOut), .deOut(deOut)
  );

  task automatic chk(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] fNarrow(input logic [11:0] w, input bit lo);
    return {(lo ? w[3:0] : 4'h0), 4'h0, w[11:4], 8'h00};
  endfunction
  function automatic logic [23:0] fWide(input logic [11:0] y, input logic [11:0] c, input bit lo);
    return {(lo ? y[3:0] : 4'h0), (lo ? c[3:0] : 4'h0), y[11:4], c[11:4]};
  endfunction
  function automatic logic [23:0] fRgb(input logic [11:0] g, input logic [11:0] b, input logic [11:0] r);
    return {r[11:4], g[11:4], b[11:4]};
  endfunction
  function automatic logic [23:0] fOe(input logic [7:0] c);
    case (c)
      8'h00, 8'h20:        return 24'h00FF00;
      8'h0A, 8'h2A:        return 24'hF0FF00;
      8'h80:               return 24'h00FFFF;
      8'h8A, 8'h40, 8'h60: return 24'hFFFFFF;
      default:             return 24'h000000;
    endcase
  endfunction
  function automatic string reqTag(input logic [7:0] c);
    case (c)
      8'h00: return "R1";
      8'h0A: return "R2";
      8'h80: return "R3";
      8'h8A: return "R4";
      8'h40: return "R5";
      8'h20: return "R6";
      8'h2A: return "R7";
      8'h60: return "R8";
      default: return "R9";
    endcase
  endfunction
  function automatic bit isSdr(input logic [7:0] c);
    return (c == 8'h00) || (c == 8'h0A) || (c == 8'h80) || (c == 8'h8A) || (c == 8'h40);
  endfunction

  task automatic checkOutputs();
    logic [23:0] p1, p0;
    string t;
    t = expBlank ? "R10" : reqTag(expCode);
    ddrPhase = 1'b1; #1; p1 = pixOut;
    ddrPhase = 1'b0; #1; p0 = pixOut;
    chk(t, "rising word", p1, mRise);
    chk(t, "falling word", p0, mFall);
    chk(reqTag(expCode), "enable mask", pixOe, expOe);
    chk((fOe(expCode) == 0) ? "R9" : "R10", "sync", {21'h0, hsOut, vsOut, deOut}, {21'h0, expSync});
    if (isSdr(expCode)) chk("R12", "phase independence", p1, p0);
  endtask

  task automatic cyc(input logic [7:0] code, input logic de, input logic hs, input logic vs,
                     input logic [11:0] y, input logic [11:0] b, input logic [11:0] r);
    logic [1:0] cur;
    bit known;
    @(negedge clk);
    if (expValid) checkOutputs();
    fmtCode = code; inDe = de; inHs = hs; inVs = vs; lumaG = y; cbB = b; crR = r;
    known = (fOe(code) != 0);
    cur = mPrevDe ? mIdx : 2'd0;
    if (!de || !known) begin
      mRise = '0; mFall = '0;
    end else begin
      case (code)
        8'h00, 8'h0A: begin
          mRise = fNarrow(cur[0] ? y : (cur[1] ? r : b), code == 8'h0A);
          mFall = mRise;
        end
        8'h80, 8'h8A: begin
          mRise = fWide(y, cur[0] ? r : b, code == 8'h8A);
          mFall = mRise;
        end
        8'h40: begin
          mRise = fRgb(y, b, r);
          mFall = mRise;
        end
        8'h20, 8'h2A: begin
          mRise = fNarrow(cur[0] ? r : b, code == 8'h2A);
          mFall = fNarrow(y, code == 8'h2A);
        end
        default: begin // 0x60
          if (cur[0]) begin
            mRise = mHold;
            mFall = fRgb(y, b, r);
          end else begin
            mHold = fRgb(y, b, r);
          end
        end
      endcase
    end
    if (de) mIdx = cur + 2'd1;
    mPrevDe = de;
    expOe = fOe(code);
    expSync = known ? {hs, vs, de} : 3'b000;
    expCode = code;
    expBlank = !de;
    expValid = 1;
  endtask

  task automatic line(input logic [7:0] code, input int n);
    for (int i = 0; i < n; i++)
      cyc(code, 1'b1, 1'b0, 1'b0, 12'h100 + 12'(i * 16'h111), 12'h200 + 12'(i * 16'h0AB), 12'h300 + 12'(i * 16'h0CD));
  endtask

  task automatic blank(input logic [7:0] code, input int n);
    for (int i = 0; i < n; i++) cyc(code, 1'b0, 1'b1, 1'b0, 12'hFFF, 12'hFFF, 12'hFFF);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [7:0] codes [8];
    logic [7:0] code;
    logic de;
    codes[0] = 8'h00; codes[1] = 8'h0A; codes[2] = 8'h80; codes[3] = 8'h8A;
    codes[4] = 8'h40; codes[5] = 8'h20; codes[6] = 8'h2A; codes[7] = 8'h60;
    void'($urandom(32'd20240611));

    // R11: reset state, with active inputs present
    fmtCode = 8'h8A; inDe = 1'b1; inHs = 1'b1; inVs = 1'b1; lumaG = 12'hABC;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "reset bus", pixOut, 24'h0);
    chk("R11", "reset enables", pixOe, 24'h0);
    chk("R11", "reset sync", {21'h0, hsOut, vsOut, deOut}, 24'h0);
    inDe = 1'b0; inHs = 1'b0; inVs = 1'b0;
    rstN = 1'b1;

    // directed corner cases for each format
    for (int k = 0; k < 8; k++) begin
      blank(codes[k], 2);
      line(codes[k], 6);
      blank(codes[k], 1);
      line(codes[k], 3);          // restart of alternation after a short gap
      blank(codes[k], 2);
    end
    // DDR RGB with odd-length line: last pixel unpaired (R8)
    line(8'h60, 5);
    blank(8'h60, 2);
    // unknown codes with active video (R9)
    line(8'h55, 4);
    line(8'hFF, 2);
    blank(8'h01, 2);
    // mode switch inside a line
    line(8'h00, 3);
    line(8'h20, 3);
    line(8'h60, 3);
    line(8'h8A, 2);
    blank(8'h00, 1);

    // constrained random mix
    code = 8'h00;
    de = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (i % 37 == 0) begin
        if ($urandom % 10 < 8) code = codes[$urandom % 8];
        else code = 8'($urandom);
      end
      if ($urandom % 8 == 0) de = ~de;
      cyc(code, de, 1'($urandom), 1'($urandom), 12'($urandom), 12'($urandom), 12'($urandom));
    end
    @(negedge clk);
    checkOutputs();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule